// File: doc/BRIEF.md
# Single-Precision NaN Resolver and Comparator

This unit sits beside a binary32 floating-point datapath and settles every case in which a NaN is involved. Each accepted request carries two operands, an operation class and a default-NaN mode bit. One cycle later the unit returns one of three things: the NaN-adjusted result, the NZCV flags of a comparison, or a pass-through indication. The pass-through indication tells the normal arithmetic datapath that no NaN was present and that it must produce the result itself. An invalid-operation indication comes with every response.

The class decides how NaNs are treated. Arithmetic propagates and quiets NaNs, or replaces them with the default NaN when that mode is on. The sign-only operations (copy, negate, absolute value) and plain moves carry NaNs through untouched. Quiet and signaling compares differ only in when they report an invalid operation. Requests arrive on a valid strobe, and every response is registered.

Top module: `fpnan_unit`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. It is a signaling NaN when fraction bit 22 is clear and a quiet NaN when that bit is set. Quieting means setting bit 22.
- R2: Arithmetic (op code 0) with default-NaN mode off and at least one signaling NaN operand asserts invalid. The result is the quieted form of operand A if A is signaling, otherwise the quieted form of operand B. A signaling NaN is preferred over a quiet NaN in the other operand.
- R3: Arithmetic with default-NaN mode off and only quiet NaN operands returns operand A if it is a quiet NaN, otherwise operand B, unchanged and with invalid low.
- R4: Arithmetic with default-NaN mode on and any NaN operand returns 0x7FC00000. Invalid is asserted only if an operand is a signaling NaN.
- R5: Arithmetic with no NaN operand (infinities included) asserts pass-through, returns result 0 and keeps invalid low. Pass-through is low for every other case.
- R6: Copy (code 1), negate (code 2) and absolute value (code 3) act on operand A only. Negate inverts bit 31, absolute value clears bit 31, and all other bits pass unchanged, signaling NaNs included. These operations never assert invalid, in either mode.
- R7: Quiet compare (code 4) reports NZCV 0011 when either operand is a NaN, and asserts invalid only when an operand is a signaling NaN.
- R8: Signaling compare (code 5) reports NZCV 0011 and asserts invalid when either operand is any NaN.
- R9: A compare of two non-NaN operands reports NZCV 0110 for A equal to B (positive and negative zero are equal), 1000 for A less than B, and 0010 for A greater than B.
- R10: Move (code 6, and unused code 7) returns operand A bit for bit and never asserts invalid.
- R11: A response is valid exactly one cycle after an accepted request. Synchronous reset clears out_valid, the result, the flags, invalid and pass-through to zero.
- R12: Non-compare operations report NZCV 0000, and compares return result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation class code |
| in_dn | input | 1 | Default-NaN mode |
| in_a | input | 32 | Operand A, binary32 |
| in_b | input | 32 | Operand B, binary32 |
| out_valid | output | 1 | Response strobe |
| out_result | output | 32 | NaN-adjusted or moved value |
| out_nzcv | output | 4 | Compare flags N,Z,C,V |
| out_invalid | output | 1 | Invalid-operation indication |
| out_passthru | output | 1 | Arithmetic with no NaN, handled elsewhere |

## Verification
Every path in the unit passes through a single register stage, so a wrong classification, selection or ordering decision shows at the ports in the response cycle that follows the request. It appears as a wrong payload bit, a wrong flag nibble or a wrong invalid or pass-through bit. The vectors target the decisions that separate the classes: signaling against quiet at bit 22, operand priority when both operands are NaNs, mode-dependent default-NaN substitution, and the sign and zero corners of ordering.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam int QBIT   = FRAC_W - 1;
    localparam int FLG_W  = 4;

    typedef enum logic [2:0] {
        OP_ARITH = 3'd0,
        OP_COPY  = 3'd1,
        OP_NEG   = 3'd2,
        OP_ABS   = 3'd3,
        OP_CMPQ  = 3'd4,
        OP_CMPS  = 3'd5,
        OP_MOVE  = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_qnan;
        logic is_zero;
    } cls_t;

    typedef struct packed {
        logic [W-1:0]     result;
        logic [FLG_W-1:0] nzcv;
        logic             invalid;
        logic             passthru;
    } res_t;

    localparam logic [FLG_W-1:0] NZCV_EQ  = 4'b0110;
    localparam logic [FLG_W-1:0] NZCV_LT  = 4'b1000;
    localparam logic [FLG_W-1:0] NZCV_GT  = 4'b0010;
    localparam logic [FLG_W-1:0] NZCV_UN  = 4'b0011;
    localparam logic [FLG_W-1:0] NZCV_NONE = 4'b0000;

    localparam fp_t DEFAULT_NAN = '{sign: 1'b0,
                                    exp:  {EXP_W{1'b1}},
                                    frac: {1'b1, {(FRAC_W-1){1'b0}}}};

    function automatic fp_t quieten(fp_t x);
        fp_t y;
        y = x;
        y.frac[QBIT] = 1'b1;
        return y;
    endfunction
endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify
    import fpnan_pkg::*;
(
    input  fp_t  x,
    output cls_t c
);
    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones  = &x.exp;
        frac_nz   = |x.frac;
        c.is_nan  = exp_ones & frac_nz;
        c.is_qnan = exp_ones & frac_nz & x.frac[QBIT];
        c.is_snan = exp_ones & frac_nz & ~x.frac[QBIT];
        c.is_zero = (x.exp == '0) && (x.frac == '0);
    end
endmodule

// File: rtl/fpnan_select.sv
module fpnan_select
    import fpnan_pkg::*;
(
    input  fp_t  a,
    input  fp_t  b,
    input  cls_t ca,
    input  cls_t cb,
    input  logic dn,
    output fp_t  nan_out,
    output logic any_nan,
    output logic any_snan
);
    always_comb begin
        any_snan = ca.is_snan | cb.is_snan;
        any_nan  = ca.is_nan  | cb.is_nan;
        if (!any_nan)
            nan_out = '0;
        else if (dn)
            nan_out = DEFAULT_NAN;
        else if (ca.is_snan)
            nan_out = quieten(a);
        else if (cb.is_snan)
            nan_out = quieten(b);
        else if (ca.is_qnan)
            nan_out = a;
        else
            nan_out = b;
    end
endmodule

// File: rtl/fpnan_unary.sv
module fpnan_unary
    import fpnan_pkg::*;
(
    input  op_e op,
    input  fp_t a,
    output fp_t y
);
    always_comb begin
        y = a;
        unique case (op)
            OP_NEG:  y.sign = ~a.sign;
            OP_ABS:  y.sign = 1'b0;
            default: y.sign = a.sign;
        endcase
    end
endmodule

// File: rtl/fpnan_compare.sv
module fpnan_compare
    import fpnan_pkg::*;
(
    input  fp_t               a,
    input  fp_t               b,
    input  cls_t              ca,
    input  cls_t              cb,
    output logic [FLG_W-1:0]  nzcv
);
    localparam int MAG_W = EXP_W + FRAC_W;

    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             lt;

    always_comb begin
        mag_a = {a.exp, a.frac};
        mag_b = {b.exp, b.frac};
        lt    = 1'b0;
        if (ca.is_nan || cb.is_nan) begin
            nzcv = NZCV_UN;
        end else if ((ca.is_zero && cb.is_zero) || (a == b)) begin
            nzcv = NZCV_EQ;
        end else begin
            if (a.sign != b.sign)
                lt = a.sign;
            else if (a.sign)
                lt = mag_a > mag_b;
            else
                lt = mag_a < mag_b;
            nzcv = lt ? NZCV_LT : NZCV_GT;
        end
    end
endmodule

// File: rtl/fpnan_unit.sv
module fpnan_unit
    import fpnan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic             in_dn,
    input  logic [W-1:0]     in_a,
    input  logic [W-1:0]     in_b,
    output logic             out_valid,
    output logic [W-1:0]     out_result,
    output logic [FLG_W-1:0] out_nzcv,
    output logic             out_invalid,
    output logic             out_passthru
);
    localparam int NOPND = 2;

    op_e              op;
    fp_t              opnd [NOPND];
    cls_t             cls  [NOPND];
    fp_t              nan_out;
    fp_t              uny;
    logic             any_nan;
    logic             any_snan;
    logic [FLG_W-1:0] cmp_flags;
    res_t             nxt;
    res_t             q;
    logic             vld_q;

    assign op      = op_e'(in_op);
    assign opnd[0] = fp_t'(in_a);
    assign opnd[1] = fp_t'(in_b);

    for (genvar i = 0; i < NOPND; i++) begin : g_cls
        fpnan_classify u_cls (.x(opnd[i]), .c(cls[i]));
    end

    fpnan_select u_sel (
        .a(opnd[0]), .b(opnd[1]), .ca(cls[0]), .cb(cls[1]), .dn(in_dn),
        .nan_out(nan_out), .any_nan(any_nan), .any_snan(any_snan)
    );

    fpnan_unary u_uny (.op(op), .a(opnd[0]), .y(uny));

    fpnan_compare u_cmp (
        .a(opnd[0]), .b(opnd[1]), .ca(cls[0]), .cb(cls[1]), .nzcv(cmp_flags)
    );

    always_comb begin
        nxt = '0;
        unique case (op)
            OP_ARITH: begin
                if (any_nan) begin
                    nxt.result  = nan_out;
                    nxt.invalid = any_snan;
                end else begin
                    nxt.passthru = 1'b1;
                end
            end
            OP_COPY, OP_NEG, OP_ABS: nxt.result = uny;
            OP_CMPQ: begin
                nxt.nzcv    = cmp_flags;
                nxt.invalid = any_snan;
            end
            OP_CMPS: begin
                nxt.nzcv    = cmp_flags;
                nxt.invalid = any_nan;
            end
            default: nxt.result = in_a;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            q     <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                q <= nxt;
        end
    end

    assign out_valid    = vld_q;
    assign out_result   = q.result;
    assign out_nzcv     = q.nzcv;
    assign out_invalid  = q.invalid;
    assign out_passthru = q.passthru;

    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_dnan_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_ARITH && in_dn && (cls[0].is_nan || cls[1].is_nan))
        |=> (out_result == DEFAULT_NAN));
    p_move_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_MOVE) |=> (!out_invalid && out_result == $past(in_a)));
    p_cmps_nan_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_CMPS && (cls[0].is_nan || cls[1].is_nan))
        |=> (out_invalid && out_nzcv == NZCV_UN));
    p_flags_legal_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_nzcv == NZCV_NONE || out_nzcv == NZCV_EQ ||
                       out_nzcv == NZCV_LT   || out_nzcv == NZCV_GT || out_nzcv == NZCV_UN));
    p_pass_clean_r5: assert property (@(posedge clk) disable iff (rst)
        out_passthru |-> (!out_invalid && out_result == '0));
    p_sign_only_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_NEG || op == OP_ABS || op == OP_COPY))
        |=> (!out_invalid && out_result[W-2:0] == $past(in_a[W-2:0])));
endmodule

// File: tb/sim_fpnan_unit.sv
module sim_fpnan_unit;
    localparam int NV = 30;

    typedef struct packed {
        logic [2:0]  op;
        logic        dn;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic [3:0]  nzcv;
        logic        inv;
        logic        pass;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b0, 32'h7FFFFFFF, 32'h3F800000, 32'h7FFFFFFF, 4'b0000, 1'b0, 1'b0, 4'd1},  // R1 quiet (bit22 set)
        '{3'd0, 1'b0, 32'h7FBFFFFF, 32'h3F800000, 32'h7FFFFFFF, 4'b0000, 1'b1, 1'b0, 4'd1},  // R1 signaling
        '{3'd0, 1'b0, 32'h7F800001, 32'h3F800000, 32'h7FC00001, 4'b0000, 1'b1, 1'b0, 4'd2},  // R2
        '{3'd0, 1'b0, 32'h3F800000, 32'hFF800005, 32'hFFC00005, 4'b0000, 1'b1, 1'b0, 4'd2},  // R2
        '{3'd0, 1'b0, 32'h7F800001, 32'hFF800005, 32'h7FC00001, 4'b0000, 1'b1, 1'b0, 4'd2},  // R2 A first
        '{3'd0, 1'b0, 32'h7FC00001, 32'hFF800005, 32'hFFC00005, 4'b0000, 1'b1, 1'b0, 4'd2},  // R2 sNaN wins
        '{3'd0, 1'b0, 32'h7FC00001, 32'hFFC12345, 32'h7FC00001, 4'b0000, 1'b0, 1'b0, 4'd3},  // R3
        '{3'd0, 1'b0, 32'h3F800000, 32'hFFC12345, 32'hFFC12345, 4'b0000, 1'b0, 1'b0, 4'd3},  // R3
        '{3'd0, 1'b1, 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 4'b0000, 1'b0, 1'b0, 4'd4},  // R4
        '{3'd0, 1'b1, 32'h3F800000, 32'hFF800005, 32'h7FC00000, 4'b0000, 1'b1, 1'b0, 4'd4},  // R4
        '{3'd0, 1'b0, 32'h3F800000, 32'h40000000, 32'h00000000, 4'b0000, 1'b0, 1'b1, 4'd5},  // R5 R12
        '{3'd0, 1'b1, 32'h7F800000, 32'hFF800000, 32'h00000000, 4'b0000, 1'b0, 1'b1, 4'd5},  // R5 infinities
        '{3'd2, 1'b0, 32'h7F800001, 32'h3F800000, 32'hFF800001, 4'b0000, 1'b0, 1'b0, 4'd6},  // R6 negate
        '{3'd3, 1'b1, 32'hFF800005, 32'h3F800000, 32'h7F800005, 4'b0000, 1'b0, 1'b0, 4'd6},  // R6 abs
        '{3'd1, 1'b1, 32'hFFC12345, 32'h7F800001, 32'hFFC12345, 4'b0000, 1'b0, 1'b0, 4'd6},  // R6 copy
        '{3'd2, 1'b0, 32'h3F800000, 32'h7FC00001, 32'hBF800000, 4'b0000, 1'b0, 1'b0, 4'd6},  // R6
        '{3'd4, 1'b0, 32'h7FC00001, 32'h3F800000, 32'h00000000, 4'b0011, 1'b0, 1'b0, 4'd7},  // R7 R12
        '{3'd4, 1'b0, 32'h3F800000, 32'hFF800005, 32'h00000000, 4'b0011, 1'b1, 1'b0, 4'd7},  // R7
        '{3'd5, 1'b0, 32'h7FC00001, 32'h3F800000, 32'h00000000, 4'b0011, 1'b1, 1'b0, 4'd8},  // R8
        '{3'd5, 1'b1, 32'h3F800000, 32'hFF800005, 32'h00000000, 4'b0011, 1'b1, 1'b0, 4'd8},  // R8
        '{3'd5, 1'b0, 32'h3F800000, 32'h40000000, 32'h00000000, 4'b1000, 1'b0, 1'b0, 4'd9},  // R9
        '{3'd4, 1'b0, 32'h40000000, 32'h3F800000, 32'h00000000, 4'b0010, 1'b0, 1'b0, 4'd9},  // R9
        '{3'd4, 1'b0, 32'h00000000, 32'h80000000, 32'h00000000, 4'b0110, 1'b0, 1'b0, 4'd9},  // R9 zeros
        '{3'd5, 1'b0, 32'hBF800000, 32'h3F800000, 32'h00000000, 4'b1000, 1'b0, 1'b0, 4'd9},  // R9
        '{3'd4, 1'b0, 32'hBF800000, 32'hBFC00000, 32'h00000000, 4'b0010, 1'b0, 1'b0, 4'd9},  // R9 negatives
        '{3'd4, 1'b0, 32'hFF800000, 32'hBF800000, 32'h00000000, 4'b1000, 1'b0, 1'b0, 4'd9},  // R9
        '{3'd4, 1'b0, 32'h3F800000, 32'h3F800000, 32'h00000000, 4'b0110, 1'b0, 1'b0, 4'd9},  // R9
        '{3'd6, 1'b1, 32'h7F800001, 32'h7FC00001, 32'h7F800001, 4'b0000, 1'b0, 1'b0, 4'd10}, // R10
        '{3'd6, 1'b0, 32'hFFC12345, 32'h3F800000, 32'hFFC12345, 4'b0000, 1'b0, 1'b0, 4'd10}, // R10
        '{3'd7, 1'b0, 32'hFF800005, 32'h3F800000, 32'hFF800005, 4'b0000, 1'b0, 1'b0, 4'd10}  // R10 code 7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic        in_dn = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [3:0]  out_nzcv;
    logic        out_invalid;
    logic        out_passthru;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fpnan_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_dn(in_dn),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
        .out_nzcv(out_nzcv), .out_invalid(out_invalid), .out_passthru(out_passthru)
    );

    task automatic check(input string tag, input logic [38:0] act, input logic [38:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset", {out_valid, out_result, out_nzcv, out_invalid, out_passthru}, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 idle", {out_valid, 38'b0}, '0);

        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            in_op    = VEC[i].op;
            in_dn    = VEC[i].dn;
            in_a     = VEC[i].a;
            in_b     = VEC[i].b;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("vec %0d R%0d", i, VEC[i].req),
                  {out_valid, out_result, out_nzcv, out_invalid, out_passthru},
                  {1'b1, VEC[i].res, VEC[i].nzcv, VEC[i].inv, VEC[i].pass});
        end

        // R11: no request, no response
        @(negedge clk);
        check("R11 no strobe", {out_valid, 38'b0}, '0);

        // R11: back-to-back requests, reset afterwards
        in_valid = 1'b1; in_op = 3'd6; in_a = 32'h12345678; in_b = '0;
        @(negedge clk);
        check("R11 b2b first", {out_valid, out_result, 6'b0}, {1'b1, 32'h12345678, 6'b0});
        in_op = 3'd0; in_dn = 1'b0; in_a = 32'h7F800001; in_b = 32'h7FC00002;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 b2b second", {out_valid, out_result, out_nzcv, out_invalid, out_passthru},
              {1'b1, 32'h7FC00001, 4'b0000, 1'b1, 1'b0});
        rst = 1'b1;
        @(negedge clk);
        check("R11 reset clears", {out_valid, out_result, out_nzcv, out_invalid, out_passthru}, '0);
        rst = 1'b0;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule